// File: doc/BRIEF.md
# Four-Channel DMA Engine with Buffered and Fly-By Transfers

The engine moves 16-bit items between a peripheral data port and a word-addressed memory port for four independent channels. Each channel holds an active transfer: a start byte address, an item count, a direction and a mode. It also has a one-deep queue where the next transfer can wait. A channel moves items while its request line is high. Pending channels are served in fixed priority, and exactly one item is moved per grant before arbitration runs again.

A buffered (normal) item uses two bus cycles. In the first cycle the source is read and the word is captured in an internal holding register. In the second cycle the captured word is written to the destination. A fly-by item uses a single bus cycle. The source read strobe and the destination write strobe are raised together, and the data passes straight from one port to the other. When the last item of a transfer completes, a queued descriptor, if there is one, takes over at once. If there is none, the channel goes idle and sets a sticky done flag that drives the interrupt line.

Descriptors are written through a one-cycle load strobe with a channel index. A load to an idle channel starts it. A load to a busy channel fills its queue.

Top module: `dma_flyby_engine`

## Requirements
- R1: After reset no channel is active, all bus strobes and `dack` are 0, and `done` and `irq` are 0. A load to an idle channel makes it active, but no item moves while its `dreq` bit is low.
- R2: A buffered item takes two consecutive bus cycles. The first cycle raises only the source read strobe, and the second cycle raises only the destination write strobe with the word captured in the first cycle. Consecutive items of one channel start 3 cycles apart.
- R3: A fly-by item takes one bus cycle with the source read strobe and the destination write strobe both high. The write data equals the read data of that same cycle. Consecutive items start 2 cycles apart.
- R4: Direction bit 0 moves data from the peripheral to memory (`per_rd`, `mem_wr`). Direction bit 1 moves data from memory to the peripheral (`mem_rd`, `per_wr`).
- R5: `mem_addr` carries the channel's current byte address. The address advances by 2 and the count falls by 1 after each item.
- R6: A load to a busy channel with an empty queue is queued. When the final item completes, the queued descriptor becomes active on the same edge, keeping its own mode and direction. Its first item starts 3 cycles after the final buffered item's read cycle, and `done` is not raised in between.
- R7: A load to a channel whose queue is full is ignored. A load with count 0 is ignored.
- R8: Channel 0 has the highest priority and channel 3 the lowest. After every item, arbitration runs again among the channels that are active with `dreq` high.
- R9: `done[i]` is set when channel i completes its final item with an empty queue, and it stays set until `done_clr[i]` is pulsed. `irq` is the OR of all `done` bits.
- R10: `mem_rd` and `mem_wr` are never high together, `per_rd` and `per_wr` are never high together, and at most one `dack` bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Descriptor load strobe |
| cfg_ch | input | 2 | Channel index for the load |
| cfg_addr | input | 16 | Start byte address |
| cfg_cnt | input | 8 | Item count |
| cfg_dir | input | 1 | 0: peripheral to memory, 1: memory to peripheral |
| cfg_fly | input | 1 | 1: fly-by mode, 0: buffered mode |
| dreq | input | 4 | Per-channel transfer request |
| dack | output | 4 | One-hot grant, high during the item's bus cycles |
| done_clr | input | 4 | Per-channel done clear |
| done | output | 4 | Sticky per-channel completion flags |
| irq | output | 1 | OR of the done flags |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| per_rd | output | 1 | Peripheral read strobe |
| per_wr | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |

## Verification
A corrupted address or count register shows up within one item as a memory word written at the wrong location, or as a transfer that ends with the wrong number of words. The bench therefore compares every written word against an arithmetic pattern. A faulty holding register or mode selection changes the strobe pattern in the very next bus cycle. Faulty queue or priority state shows up as an out-of-order sequence of granted channels in the log of read cycles, or as an early `done`, once the current item ends.

// File: rtl/dma_flyby_pkg.sv
package dma_flyby_pkg;
   typedef enum logic [1:0] {
      SQ_ARB = 2'd0,
      SQ_RD  = 2'd1,
      SQ_WR  = 2'd2,
      SQ_FLY = 2'd3
   } seq_state_e;

   localparam logic DIR_P2M = 1'b0;
   localparam logic DIR_M2P = 1'b1;
endpackage

// File: rtl/dma_chan.sv
module dma_chan #(
   parameter int AW     = 16,
   parameter int CW     = 8,
   parameter int STEP   = 2,
   parameter bit FLY_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_en,
   input  logic [AW-1:0] ld_addr,
   input  logic [CW-1:0] ld_cnt,
   input  logic          ld_dir,
   input  logic          ld_fly,
   input  logic          step,
   input  logic          done_clr,
   input  logic          dreq,
   output logic          req,
   output logic [AW-1:0] cur_addr,
   output logic          cur_dir,
   output logic          cur_fly,
   output logic          done
);
   logic          act, qv;
   logic [AW-1:0] a_addr, q_addr;
   logic [CW-1:0] a_cnt, q_cnt;
   logic          a_dir, q_dir, a_fly, q_fly;
   logic          last, accept;

   assign last   = step && (a_cnt == CW'(1));
   assign accept = ld_en && (ld_cnt != '0) && !(act && qv);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act    <= 1'b0;
         qv     <= 1'b0;
         a_addr <= '0;
         a_cnt  <= '0;
         a_dir  <= 1'b0;
         a_fly  <= 1'b0;
         q_addr <= '0;
         q_cnt  <= '0;
         q_dir  <= 1'b0;
         q_fly  <= 1'b0;
         done   <= 1'b0;
      end else begin
         if (step) begin
            if (last) begin
               if (qv) begin
                  a_addr <= q_addr;
                  a_cnt  <= q_cnt;
                  a_dir  <= q_dir;
                  a_fly  <= q_fly;
                  qv     <= 1'b0;
               end else begin
                  act <= 1'b0;
               end
            end else begin
               a_addr <= a_addr + AW'(STEP);
               a_cnt  <= a_cnt - CW'(1);
            end
         end
         if (accept) begin
            if (!act || last) begin
               a_addr <= ld_addr;
               a_cnt  <= ld_cnt;
               a_dir  <= ld_dir;
               a_fly  <= ld_fly;
               act    <= 1'b1;
            end else begin
               q_addr <= ld_addr;
               q_cnt  <= ld_cnt;
               q_dir  <= ld_dir;
               q_fly  <= ld_fly;
               qv     <= 1'b1;
            end
         end
         if (last && !qv)
            done <= 1'b1;
         else if (done_clr)
            done <= 1'b0;
      end
   end

   assign req      = act && dreq;
   assign cur_addr = a_addr;
   assign cur_dir  = a_dir;

   if (FLY_EN) begin : g_fly_mode
      assign cur_fly = a_fly;
   end else begin : g_buf_only
      assign cur_fly = 1'b0;
   end

   // R5: a non-final item advances address and count
   p_step_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (step && a_cnt > CW'(1) && !accept) |=>
         ((a_addr - $past(a_addr)) == AW'(STEP)) && ($past(a_cnt) - a_cnt == CW'(1)));

   // R6: the final item hands over to the queued descriptor
   p_queue_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (last && qv) |=> (act && !qv && a_addr == $past(q_addr) && a_cnt == $past(q_cnt)));

   // R7: a full queue is not overwritten
   p_full_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (act && qv && !last) |=> (qv && $stable(q_addr) && $stable(q_cnt)));

   // R9: done rises only on a final item with nothing queued
   p_done_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(step) && $past(a_cnt) == CW'(1) && !$past(qv)));

   p_step_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> act);
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int N    = 4,
   parameter int IDXW = 2
) (
   input  logic [N-1:0]    req,
   output logic [N-1:0]    gnt,
   output logic            any,
   output logic [IDXW-1:0] idx
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_rank
      assign gnt[i]    = req[i] && !seen[i];
      assign seen[i+1] = seen[i] || req[i];
   end

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (gnt[i]) idx = IDXW'(i);
      end
   end
endmodule

// File: rtl/dma_bus_seq.sv
module dma_bus_seq
   import dma_flyby_pkg::*;
#(
   parameter int N      = 4,
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int IDXW   = 2,
   parameter bit FLY_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 any_req,
   input  logic [IDXW-1:0]      gnt_idx,
   input  logic [N-1:0][AW-1:0] ch_addr,
   input  logic [N-1:0]         ch_dir,
   input  logic [N-1:0]         ch_fly,
   output logic [N-1:0]         step,
   output logic [N-1:0]         dack,
   output logic [AW-1:0]        mem_addr,
   output logic                 mem_rd,
   output logic                 mem_wr,
   output logic [DW-1:0]        mem_wdata,
   input  logic [DW-1:0]        mem_rdata,
   output logic                 per_rd,
   output logic                 per_wr,
   output logic [DW-1:0]        per_wdata,
   input  logic [DW-1:0]        per_rdata
);
   seq_state_e      st;
   logic [IDXW-1:0] sel;
   logic [DW-1:0]   hold;
   logic            busy, dir, src_ph, dst_ph, fly_ph;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= SQ_ARB;
         sel  <= '0;
         hold <= '0;
      end else begin
         unique case (st)
            SQ_ARB: if (any_req) begin
               sel <= gnt_idx;
               st  <= ch_fly[gnt_idx] ? SQ_FLY : SQ_RD;
            end
            SQ_RD: begin
               hold <= (ch_dir[sel] == DIR_M2P) ? mem_rdata : per_rdata;
               st   <= SQ_WR;
            end
            SQ_WR:  st <= SQ_ARB;
            SQ_FLY: st <= SQ_ARB;
         endcase
      end
   end

   assign busy   = (st != SQ_ARB);
   assign dir    = ch_dir[sel];
   assign fly_ph = (st == SQ_FLY);
   assign src_ph = (st == SQ_RD) || fly_ph;
   assign dst_ph = (st == SQ_WR) || fly_ph;

   always_comb begin
      dack = '0;
      step = '0;
      if (busy) dack[sel] = 1'b1;
      if (dst_ph) step[sel] = 1'b1;
   end

   assign mem_addr = busy ? ch_addr[sel] : '0;
   assign per_rd   = (dir == DIR_P2M) && src_ph;
   assign mem_wr   = (dir == DIR_P2M) && dst_ph;
   assign mem_rd   = (dir == DIR_M2P) && src_ph;
   assign per_wr   = (dir == DIR_M2P) && dst_ph;

   if (FLY_EN) begin : g_fly_path
      assign mem_wdata = !mem_wr ? '0 : (fly_ph ? per_rdata : hold);
      assign per_wdata = !per_wr ? '0 : (fly_ph ? mem_rdata : hold);
   end else begin : g_buf_path
      assign mem_wdata = mem_wr ? hold : '0;
      assign per_wdata = per_wr ? hold : '0;
   end

   // R10: bus strobes and grants stay exclusive
   p_bus_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr) && !(per_rd && per_wr) && $onehot0(dack));

   // R2: buffered write phase carries the word read one cycle earlier
   p_buf_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_WR) |->
         ((dir == DIR_P2M) ? (mem_wdata == $past(per_rdata)) : (per_wdata == $past(mem_rdata))));

   // R3: a fly-by cycle raises both strobes and ends the grant
   p_fly_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (st == SQ_FLY) |-> ((per_rd && mem_wr) || (mem_rd && per_wr)) ##1 (dack == '0));
endmodule

// File: rtl/dma_flyby_engine.sv
module dma_flyby_engine #(
   parameter int NCH    = 4,
   parameter int AW     = 16,
   parameter int DW     = 16,
   parameter int CW     = 8,
   parameter bit FLY_EN = 1'b1,
   localparam int IDXW  = $clog2(NCH),
   localparam int STEP  = DW / 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [IDXW-1:0] cfg_ch,
   input  logic [AW-1:0]   cfg_addr,
   input  logic [CW-1:0]   cfg_cnt,
   input  logic            cfg_dir,
   input  logic            cfg_fly,
   input  logic [NCH-1:0]  dreq,
   output logic [NCH-1:0]  dack,
   input  logic [NCH-1:0]  done_clr,
   output logic [NCH-1:0]  done,
   output logic            irq,
   output logic [AW-1:0]   mem_addr,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   output logic            per_rd,
   output logic            per_wr,
   output logic [DW-1:0]   per_wdata,
   input  logic [DW-1:0]   per_rdata
);
   if (DW != 8 && DW != 16) begin : g_bad_dw
      $error("dma_flyby_engine: data width must be 8 or 16");
   end
   if (NCH < 2) begin : g_bad_nch
      $error("dma_flyby_engine: at least two channels required");
   end
   if (CW < 1 || AW < 2) begin : g_bad_w
      $error("dma_flyby_engine: count or address width too small");
   end

   logic [NCH-1:0]         req_v, step_v, gnt_v, dir_v, fly_v;
   logic [NCH-1:0][AW-1:0] addr_v;
   logic                   any_req;
   logic [IDXW-1:0]        gnt_idx;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      dma_chan #(
         .AW(AW), .CW(CW), .STEP(STEP), .FLY_EN(FLY_EN)
      ) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .ld_en    (cfg_we && (cfg_ch == IDXW'(i))),
         .ld_addr  (cfg_addr),
         .ld_cnt   (cfg_cnt),
         .ld_dir   (cfg_dir),
         .ld_fly   (cfg_fly),
         .step     (step_v[i]),
         .done_clr (done_clr[i]),
         .dreq     (dreq[i]),
         .req      (req_v[i]),
         .cur_addr (addr_v[i]),
         .cur_dir  (dir_v[i]),
         .cur_fly  (fly_v[i]),
         .done     (done[i])
      );
   end

   dma_prio_arb #(.N(NCH), .IDXW(IDXW)) u_arb (
      .req (req_v),
      .gnt (gnt_v),
      .any (any_req),
      .idx (gnt_idx)
   );

   dma_bus_seq #(
      .N(NCH), .AW(AW), .DW(DW), .IDXW(IDXW), .FLY_EN(FLY_EN)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .any_req   (any_req),
      .gnt_idx   (gnt_idx),
      .ch_addr   (addr_v),
      .ch_dir    (dir_v),
      .ch_fly    (fly_v),
      .step      (step_v),
      .dack      (dack),
      .mem_addr  (mem_addr),
      .mem_rd    (mem_rd),
      .mem_wr    (mem_wr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .per_rd    (per_rd),
      .per_wr    (per_wr),
      .per_wdata (per_wdata),
      .per_rdata (per_rdata)
   );

   assign irq = |done;

   // R8: an idle bus with channel 0 pending grants channel 0 next
   p_prio_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dack == '0 && req_v[0]) |=> dack[0]);

   // R8: the granted channel was the highest-ranked requester
   p_gnt_rank_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (dack == '0 && any_req) |=> (dack == $past(gnt_v)));
endmodule

// File: tb/dma_flyby_engine_tb.sv
`timescale 1ns/1ps
module dma_flyby_engine_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_ch = '0;
   logic [15:0] cfg_addr = '0;
   logic [7:0]  cfg_cnt = '0;
   logic        cfg_dir = 1'b0, cfg_fly = 1'b0;
   logic [3:0]  dreq = '0, done_clr = '0;
   logic [3:0]  dack, done;
   logic        irq, mem_rd, mem_wr, per_rd, per_wr;
   logic [15:0] mem_addr, mem_wdata, mem_rdata, per_wdata, per_rdata;

   always #2.5 clk = ~clk;

   dma_flyby_engine u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
      .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .cfg_dir(cfg_dir), .cfg_fly(cfg_fly),
      .dreq(dreq), .dack(dack), .done_clr(done_clr), .done(done), .irq(irq),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .per_rd(per_rd), .per_wr(per_wr),
      .per_wdata(per_wdata), .per_rdata(per_rdata)
   );

   // memory model: 256 words, preset to 0xC000|index during reset
   logic [15:0] mem [256];
   logic [11:0] pcnt [4];
   int          dsel;

   always_comb begin
      dsel = 0;
      for (int i = 0; i < 4; i++) if (dack[i]) dsel = i;
   end
   assign mem_rdata = mem[mem_addr[8:1]];
   assign per_rdata = {4'(dsel), pcnt[dsel]};

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) mem[k] <= 16'hC000 | 16'(k);
         for (int k = 0; k < 4; k++) pcnt[k] <= '0;
      end else begin
         if (mem_wr) mem[mem_addr[8:1]] <= mem_wdata;
         if (per_rd) pcnt[dsel] <= pcnt[dsel] + 12'd1;
      end
   end

   // monitors, sampled mid-cycle
   int cyc = 0;
   int n_prd, n_mwr, n_pm, n_mrd, n_pwr, n_mp, n_dack2;
   int lg_n, pw_n;
   int lg_ch [64];
   int lg_t [64];
   logic [15:0] pw_val [64];
   int checks = 0, errors = 0;

   task automatic clr_mon();
      n_prd = 0; n_mwr = 0; n_pm = 0; n_mrd = 0; n_pwr = 0; n_mp = 0;
      n_dack2 = 0; lg_n = 0; pw_n = 0;
   endtask

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (rst_n) begin
         if (per_rd && !mem_wr) n_prd = n_prd + 1;
         if (mem_wr && !per_rd) n_mwr = n_mwr + 1;
         if (per_rd && mem_wr)  n_pm  = n_pm + 1;
         if (mem_rd && !per_wr) n_mrd = n_mrd + 1;
         if (per_wr && !mem_rd) n_pwr = n_pwr + 1;
         if (mem_rd && per_wr)  n_mp  = n_mp + 1;
         if (dack[2]) n_dack2 = n_dack2 + 1;
         if ((per_rd || mem_rd) && lg_n < 64) begin
            lg_ch[lg_n] = dsel;
            lg_t[lg_n]  = cyc;
            lg_n = lg_n + 1;
         end
         if (per_wr && pw_n < 64) begin
            pw_val[pw_n] = per_wdata;
            pw_n = pw_n + 1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      finish_run();
   end

   task automatic load(input int ch, input int addr, input int cnt, input bit dir, input bit fly);
      @(negedge clk);
      cfg_ch = 2'(ch); cfg_addr = 16'(addr); cfg_cnt = 8'(cnt);
      cfg_dir = dir; cfg_fly = fly; cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic wait_done(input int ch, input string tag);
      int t = 0;
      while (!done[ch] && t < 500) begin @(negedge clk); t++; end
      chk(done[ch] == 1'b1, tag, done[ch], 1);
   endtask

   task automatic clear_done();
      @(negedge clk); done_clr = 4'hF;
      @(negedge clk); done_clr = 4'h0;
   endtask

   initial begin
      clr_mon();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(dack == 0 && !mem_rd && !mem_wr && !per_rd && !per_wr, "R1 reset strobes",
          {dack, mem_rd, mem_wr, per_rd, per_wr}, 0);
      chk(done == 0 && !irq, "R1 reset done", {done, irq}, 0);

      // buffered peripheral->memory, channel 1
      clr_mon();
      load(1, 16'h0020, 5, 1'b0, 1'b0);
      repeat (6) @(negedge clk);
      chk(lg_n == 0 && dack == 0, "R1 no move without dreq", lg_n, 0);
      dreq = 4'b0010;
      wait_done(1, "R9 done after buffered run");
      dreq = 4'b0000;
      chk(n_prd == 5 && n_mwr == 5 && n_pm == 0, "R2 two-phase strobes", n_prd * 256 + n_mwr * 16 + n_pm, 16'h0550);
      chk(lg_t[1] - lg_t[0] == 3 && lg_t[4] - lg_t[3] == 3, "R2 item spacing", lg_t[1] - lg_t[0], 3);
      for (int k = 0; k < 5; k++)
         chk(mem[8'h10 + k] == {4'h1, 12'(k)}, "R5 R4 buffered word", mem[8'h10 + k], {4'h1, 12'(k)});
      chk(irq == 1'b1, "R9 irq", irq, 1);

      // fly-by peripheral->memory, channel 2
      clr_mon();
      load(2, 16'h0040, 4, 1'b0, 1'b1);
      dreq = 4'b0100;
      wait_done(2, "R9 done after fly run");
      dreq = 4'b0000;
      chk(n_pm == 4 && n_prd == 0 && n_mwr == 0, "R3 fly strobes together", n_pm, 4);
      chk(lg_t[1] - lg_t[0] == 2 && lg_t[3] - lg_t[2] == 2, "R3 item spacing", lg_t[1] - lg_t[0], 2);
      for (int k = 0; k < 4; k++)
         chk(mem[8'h20 + k] == {4'h2, 12'(k)}, "R3 fly word", mem[8'h20 + k], {4'h2, 12'(k)});

      // buffered memory->peripheral, channel 0
      clr_mon();
      load(0, 16'h0080, 3, 1'b1, 1'b0);
      dreq = 4'b0001;
      wait_done(0, "R9 done m2p");
      dreq = 4'b0000;
      chk(n_mrd == 3 && n_pwr == 3 && n_mp == 0, "R4 m2p buffered strobes", n_mrd * 16 + n_pwr, 16'h33);
      for (int k = 0; k < 3; k++)
         chk(pw_val[k] == (16'hC000 | 16'(8'h40 + k)), "R4 m2p word", pw_val[k], 16'hC000 | 16'(8'h40 + k));

      // fly-by memory->peripheral, channel 3
      clr_mon();
      load(3, 16'h0090, 3, 1'b1, 1'b1);
      dreq = 4'b1000;
      wait_done(3, "R9 done m2p fly");
      dreq = 4'b0000;
      chk(n_mp == 3 && n_mrd == 0 && n_pwr == 0, "R3 m2p fly strobes", n_mp, 3);
      for (int k = 0; k < 3; k++)
         chk(pw_val[k] == (16'hC000 | 16'(8'h48 + k)), "R3 m2p fly word", pw_val[k], 16'hC000 | 16'(8'h48 + k));

      // done clear
      clear_done();
      chk(done == 0 && !irq, "R9 clear", {done, irq}, 0);

      // queue: channel 1, buffered then queued fly-by, third load dropped
      clr_mon();
      load(1, 16'h0100, 2, 1'b0, 1'b0);
      load(1, 16'h0120, 3, 1'b0, 1'b1);
      load(1, 16'h0140, 2, 1'b0, 1'b0);
      dreq = 4'b0010;
      begin
         int t = 0;
         while ((n_mwr + n_pm) < 2 && t < 100) begin @(negedge clk); t++; end
      end
      chk(done[1] == 1'b0, "R6 no done at handover", done[1], 0);
      wait_done(1, "R6 done after queued run");
      dreq = 4'b0000;
      chk(n_prd == 2 && n_pm == 3, "R6 queued mode used", n_prd * 16 + n_pm, 16'h23);
      chk(lg_t[2] - lg_t[1] == 3, "R6 reload gap", lg_t[2] - lg_t[1], 3);
      for (int k = 0; k < 2; k++)
         chk(mem[8'h80 + k] == {4'h1, 12'(5 + k)}, "R6 first run word", mem[8'h80 + k], {4'h1, 12'(5 + k)});
      for (int k = 0; k < 3; k++)
         chk(mem[8'h90 + k] == {4'h1, 12'(7 + k)}, "R6 queued run word", mem[8'h90 + k], {4'h1, 12'(7 + k)});
      for (int k = 0; k < 2; k++)
         chk(mem[8'hA0 + k] == (16'hC000 | 16'(8'hA0 + k)), "R7 full queue load ignored",
             mem[8'hA0 + k], 16'hC000 | 16'(8'hA0 + k));
      chk(lg_n == 5, "R7 no extra items", lg_n, 5);

      // zero count load ignored
      clear_done();
      clr_mon();
      load(2, 16'h0060, 0, 1'b0, 1'b0);
      dreq = 4'b0100;
      repeat (10) @(negedge clk);
      dreq = 4'b0000;
      chk(n_dack2 == 0 && done[2] == 1'b0, "R7 zero count ignored", n_dack2, 0);

      // fixed priority, all four channels at once
      clear_done();
      clr_mon();
      for (int c = 0; c < 4; c++) load(c, 16'h0180 + 16 * c, 3, 1'b0, 1'b0);
      dreq = 4'hF;
      wait_done(3, "R8 lowest finishes");
      dreq = 4'h0;
      chk(done == 4'hF, "R9 all done", done, 4'hF);
      for (int k = 0; k < 12; k++)
         chk(lg_ch[k] == k / 3, "R8 priority order", lg_ch[k], k / 3);
      for (int k = 0; k < 3; k++)
         chk(mem[8'hD8 + k] == {4'h3, 12'(k)}, "R8 R5 ch3 word", mem[8'hD8 + k], {4'h3, 12'(k)});

      // re-arbitration after each item
      clear_done();
      clr_mon();
      load(0, 16'h01C0, 2, 1'b0, 1'b0);
      load(1, 16'h01D0, 2, 1'b0, 1'b0);
      dreq = 4'b0010;
      begin
         int t = 0;
         while (lg_n < 1 && t < 50) begin @(negedge clk); t++; end
      end
      dreq = 4'b0011;
      wait_done(0, "R8 ch0 done");
      wait_done(1, "R8 ch1 done");
      dreq = 4'b0000;
      chk(lg_n == 4, "R8 item count", lg_n, 4);
      chk(lg_ch[0] == 1 && lg_ch[1] == 0 && lg_ch[2] == 0 && lg_ch[3] == 1, "R8 one item per grant",
          lg_ch[0] * 4096 + lg_ch[1] * 256 + lg_ch[2] * 16 + lg_ch[3], 16'h1001);
      chk(mem[8'hE0] == {4'h0, 12'd3} && mem[8'hE8] == {4'h1, 12'd13}, "R5 preempted addresses",
          mem[8'hE8], {4'h1, 12'd13});

      finish_run();
   end
endmodule